// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This controller refills one 32-byte cache line after a miss. The cache hands it a miss request with the byte address that missed and the way chosen for replacement. The controller sends one burst read to memory for the line-aligned address and says which double word memory must return first. It then takes four 64-bit beats. The first beat is the double word that holds the missed address, and the rest follow in wrapping order. Each beat goes into the line data array as it arrives.

The first beat is also passed straight to the requesting unit in the same cycle it is written, so the requester does not wait for the whole burst. A busy output stalls every other internal cache access. It rises in the very cycle the miss is taken and stays high until the tag and valid bit are written, one cycle after the fourth beat. Because the line base is always aligned to 32 bytes, a refill can never cross a page boundary.

Top module: `line_fill_ctrl`

## Requirements
- R1: `miss_ack` is high only in a cycle where the controller is idle and `miss_req` is high. A miss request made during a refill is not acknowledged.
- R2: From the cycle after acceptance, `rd_req` is high until the cycle in which `rd_ready` is seen. During that time `rd_addr` equals the missed address with bits [4:0] cleared, and `rd_first_dw` equals bits [4:3] of the missed address.
- R3: The first beat that arrives after the read is granted is written with `wr_idx` equal to bits [4:3] of the missed address.
- R4: Beat k (k = 1, 2, 3) is written to double-word index (bits[4:3] + k) mod 4.
- R5: `fwd_valid` is high, with `fwd_data` equal to `beat_data`, in the same cycle the first beat is written. It is low for every other beat.
- R6: `busy` is high in the cycle a miss is accepted and in every later cycle up to and including the tag-write cycle. At all other times it equals `miss_req` while the controller is idle.
- R7: `beat_valid` has no effect outside the data phase: `wr_en` and `fwd_valid` stay low.
- R8: `tag_we` pulses for exactly one cycle, the cycle after the fourth beat. In that cycle `tag_value` is the missed address bits [31:12], `tag_set` is bits [11:5], and `tag_way` is the captured way.
- R9: An asynchronous reset during a refill returns the controller to idle with `busy`, `rd_req`, `wr_en` and `tag_we` low. The line is never marked valid.
- R10: Every beat write carries `wr_set` equal to missed address bits [11:5] and `wr_way` equal to the way given at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_req | input | 1 | Miss request from the cache |
| miss_addr | input | 32 | Byte address that missed |
| miss_way | input | 2 | Way selected for the refill |
| miss_ack | output | 1 | Miss taken this cycle |
| busy | output | 1 | Stall for other internal cache accesses |
| rd_req | output | 1 | Burst read request to memory |
| rd_addr | output | 32 | Line-aligned burst address |
| rd_first_dw | output | 2 | Double word memory must return first |
| rd_ready | input | 1 | Memory accepts the burst request |
| beat_valid | input | 1 | A data beat is present |
| beat_data | input | 64 | Data beat |
| wr_en | output | 1 | Write a double word into the line array |
| wr_way | output | 2 | Way of the write |
| wr_set | output | 7 | Set of the write |
| wr_idx | output | 2 | Double-word index within the line |
| wr_data | output | 64 | Data written |
| fwd_valid | output | 1 | Critical double word forwarded to requester |
| fwd_data | output | 64 | Forwarded double word |
| tag_we | output | 1 | Write tag and set the valid bit |
| tag_way | output | 2 | Way of the tag write |
| tag_set | output | 7 | Set of the tag write |
| tag_value | output | 20 | Tag written |

## Verification
The critical beat is written into the array and forwarded to the requester in one and the same cycle. Accepting a miss and raising the stall also happen together in one cycle. The bench sets up both pairs in several ways:
- the first beat arrives on the cycle right after the grant, and also after idle gaps;
- the critical index is 0, 1, 2 and 3, so every wrap distance is covered;
- the miss request is sometimes held high through a refill.

Each clock, a behavioural model predicts `wr_en`, `wr_idx`, `fwd_valid`, `fwd_data`, `miss_ack` and `busy`. The bench compares all of them in the same sample, so a forward that comes a cycle late, or one with no matching write, is reported.

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int SET_W      = 7,
  parameter int WAY_W      = 2,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 miss_req,
  input  logic [ADDR_W-1:0]    miss_addr,
  input  logic [WAY_W-1:0]     miss_way,
  output logic                 miss_ack,
  output logic                 busy,
  output logic                 rd_req,
  output logic [ADDR_W-1:0]    rd_addr,
  output logic [$clog2(LINE_BYTES)-$clog2(DATA_W/8)-1:0] rd_first_dw,
  input  logic                 rd_ready,
  input  logic                 beat_valid,
  input  logic [DATA_W-1:0]    beat_data,
  output logic                 wr_en,
  output logic [WAY_W-1:0]     wr_way,
  output logic [SET_W-1:0]     wr_set,
  output logic [$clog2(LINE_BYTES)-$clog2(DATA_W/8)-1:0] wr_idx,
  output logic [DATA_W-1:0]    wr_data,
  output logic                 fwd_valid,
  output logic [DATA_W-1:0]    fwd_data,
  output logic                 tag_we,
  output logic [WAY_W-1:0]     tag_way,
  output logic [SET_W-1:0]     tag_set,
  output logic [ADDR_W-$clog2(LINE_BYTES)-SET_W-1:0] tag_value
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BYTE_W = $clog2(DATA_W/8);
  localparam int IDX_W  = OFF_W - BYTE_W;
  localparam int BEATS  = LINE_BYTES / (DATA_W/8);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA, S_COMMIT} fill_state_t;

  fill_state_t       state;
  logic [ADDR_W-1:0] addr_q;
  logic [WAY_W-1:0]  way_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  crit;
  logic              idle;
  logic              last_beat;

  assign idle      = (state == S_IDLE);
  assign crit      = addr_q[OFF_W-1:BYTE_W];
  assign last_beat = (cnt_q == IDX_W'(BEATS-1));

  assign miss_ack    = idle & miss_req;
  assign busy        = !idle | miss_req;

  assign rd_req      = (state == S_REQ);
  assign rd_addr     = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign rd_first_dw = crit;

  assign wr_en     = (state == S_DATA) & beat_valid;
  assign wr_idx    = crit + cnt_q;
  assign wr_data   = beat_data;
  assign wr_way    = way_q;
  assign wr_set    = addr_q[OFF_W +: SET_W];

  assign fwd_valid = wr_en & (cnt_q == '0);
  assign fwd_data  = beat_data;

  assign tag_we    = (state == S_COMMIT);
  assign tag_way   = way_q;
  assign tag_set   = addr_q[OFF_W +: SET_W];
  assign tag_value = addr_q[ADDR_W-1 -: TAG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      way_q  <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (miss_req) begin
          state  <= S_REQ;
          addr_q <= miss_addr;
          way_q  <= miss_way;
          cnt_q  <= '0;
        end
        S_REQ: if (rd_ready) state <= S_DATA;
        S_DATA: if (beat_valid) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_beat) state <= S_COMMIT;
        end
        S_COMMIT: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end
endmodule

module line_fill_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_ack,
  input logic              busy,
  input logic              rd_req,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              fwd_valid,
  input logic [DATA_W-1:0] fwd_data,
  input logic              tag_we
);
  // R1
  ack_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ack |-> busy);
  // R2
  rd_addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[4:0] == 5'd0);
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ready |=> rd_req && $stable(rd_addr));
  // R5
  fwd_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> wr_en && fwd_data == wr_data);
  // R6
  activity_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || wr_en || tag_we) |-> busy);
  // R8
  commit_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |-> $past(wr_en));
  // R8
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |=> !tag_we);
endmodule

bind line_fill_ctrl line_fill_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fill_chk (
  .clk(clk), .rst_n(rst_n), .miss_ack(miss_ack), .busy(busy), .rd_req(rd_req),
  .rd_ready(rd_ready), .rd_addr(rd_addr), .wr_en(wr_en), .wr_data(wr_data),
  .fwd_valid(fwd_valid), .fwd_data(fwd_data), .tag_we(tag_we)
);

// File: tb/test_line_fill_ctrl.sv
`timescale 1ns/1ps
module test_line_fill_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_req = 1'b0;
  logic [31:0] miss_addr = '0;
  logic [1:0]  miss_way = '0;
  logic        miss_ack, busy, rd_req;
  logic [31:0] rd_addr;
  logic [1:0]  rd_first_dw;
  logic        rd_ready = 1'b0;
  logic        beat_valid = 1'b0;
  logic [63:0] beat_data = '0;
  logic        wr_en;
  logic [1:0]  wr_way;
  logic [6:0]  wr_set;
  logic [1:0]  wr_idx;
  logic [63:0] wr_data;
  logic        fwd_valid;
  logic [63:0] fwd_data;
  logic        tag_we;
  logic [1:0]  tag_way;
  logic [6:0]  tag_set;
  logic [19:0] tag_value;

  always #2.5 clk = ~clk;

  line_fill_ctrl i_line_fill_ctrl (
    .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_addr(miss_addr),
    .miss_way(miss_way), .miss_ack(miss_ack), .busy(busy), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_first_dw(rd_first_dw), .rd_ready(rd_ready),
    .beat_valid(beat_valid), .beat_data(beat_data), .wr_en(wr_en),
    .wr_way(wr_way), .wr_set(wr_set), .wr_idx(wr_idx), .wr_data(wr_data),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .tag_we(tag_we),
    .tag_way(tag_way), .tag_set(tag_set), .tag_value(tag_value)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: 0 idle, 1 request, 2 data, 3 commit
  int          m_st = 0;
  int          m_cnt = 0;
  logic [31:0] m_addr = '0;
  logic [1:0]  m_way = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0;
    end else begin
      case (m_st)
        0: if (miss_req) begin m_st = 1; m_addr = miss_addr; m_way = miss_way; m_cnt = 0; end
        1: if (rd_ready) m_st = 2;
        2: if (beat_valid) begin m_cnt++; if (m_cnt == 4) m_st = 3; end
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    logic e_ack, e_busy, e_rd, e_wr, e_fwd, e_tag;
    logic [1:0] e_idx;
    e_ack  = (m_st == 0) && miss_req;
    e_busy = (m_st != 0) || miss_req;
    e_rd   = (m_st == 1);
    e_wr   = (m_st == 2) && beat_valid;
    e_fwd  = e_wr && (m_cnt == 0);
    e_tag  = (m_st == 3);
    e_idx  = 2'((m_addr[4:3] + m_cnt) % 4);
    check(miss_ack == e_ack, "R1", "miss_ack", miss_ack, e_ack);
    check(busy == e_busy, (rst_n ? "R6" : "R9"), "busy", busy, e_busy);
    check(rd_req == e_rd, "R2", "rd_req", rd_req, e_rd);
    check(wr_en == e_wr, (m_st == 2 ? "R3" : "R7"), "wr_en", wr_en, e_wr);
    check(fwd_valid == e_fwd, "R5", "fwd_valid", fwd_valid, e_fwd);
    check(tag_we == e_tag, (rst_n ? "R8" : "R9"), "tag_we", tag_we, e_tag);
    if (e_rd) begin
      check(rd_addr == {m_addr[31:5], 5'd0}, "R2", "rd_addr", rd_addr, {m_addr[31:5], 5'd0});
      check(rd_first_dw == m_addr[4:3], "R2", "rd_first_dw", rd_first_dw, m_addr[4:3]);
    end
    if (e_wr) begin
      check(wr_idx == e_idx, (m_cnt == 0 ? "R3" : "R4"), "wr_idx", wr_idx, e_idx);
      check(wr_data == beat_data, "R4", "wr_data", wr_data, beat_data);
      check(wr_set == m_addr[11:5], "R10", "wr_set", wr_set, m_addr[11:5]);
      check(wr_way == m_way, "R10", "wr_way", wr_way, m_way);
    end
    if (e_fwd) check(fwd_data == beat_data, "R5", "fwd_data", fwd_data, beat_data);
    if (e_tag) begin
      check(tag_value == m_addr[31:12], "R8", "tag_value", tag_value, m_addr[31:12]);
      check(tag_set == m_addr[11:5], "R8", "tag_set", tag_set, m_addr[11:5]);
      check(tag_way == m_way, "R8", "tag_way", tag_way, m_way);
    end
  end

  function automatic logic [63:0] mem_word(input logic [31:0] base, input int idx);
    return {base ^ 32'h5A5A_0000, 32'(idx) * 32'h1111_1111 + 32'h0F0F};
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic fill(input logic [31:0] addr, input logic [1:0] way, input int grant_wait,
                      input int gap, input bit junk_beats, input bit hold_req,
                      input int stop_after);
    logic [31:0] base;
    int crit;
    base = {addr[31:5], 5'd0};
    crit = int'(addr[4:3]);
    miss_req = 1; miss_addr = addr; miss_way = way;
    step();
    if (!hold_req) begin miss_req = 0; miss_addr = 32'hDEAD_BEEF; end
    for (int w = 0; w < grant_wait; w++) begin
      beat_valid = junk_beats; beat_data = 64'hBAD0_BAD0_BAD0_BAD0;
      step();
    end
    beat_valid = 0;
    rd_ready = 1;
    step();
    rd_ready = 0;
    for (int k = 0; k < 4; k++) begin
      if (k == stop_after) return;
      for (int g = 0; g < gap; g++) begin beat_valid = 0; step(); end
      if (k == 3) miss_req = 0;
      beat_valid = 1;
      beat_data = mem_word(base, (crit + k) % 4);
      step();
    end
    beat_valid = 0;
    miss_req = 0;
    step();
    step();
  endtask

  initial begin
    #5000000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(busy == 0 && rd_req == 0 && wr_en == 0 && tag_we == 0, "R9", "reset state",
          {busy, rd_req, wr_en, tag_we}, 4'b0000);
    rst_n = 1;
    step();
    // R7: beats while idle must not write
    beat_valid = 1; beat_data = 64'h1234; step(); step(); beat_valid = 0; step();
    fill(32'h1234_5600, 2'd0, 0, 0, 0, 0, 4);   // R3 crit 0, back to back
    fill(32'h89AB_C0F8, 2'd3, 3, 2, 1, 0, 4);   // R4 crit 3, gaps, junk in request phase
    fill(32'h0000_0FE8, 2'd1, 1, 0, 0, 1, 4);   // R1 miss held during refill, crit 1
    fill(32'hFFFF_FFF0, 2'd2, 0, 1, 0, 0, 4);   // R4 crit 2
    fill(32'h4444_4418, 2'd1, 0, 0, 0, 0, 2);   // R9 reset after two beats
    rst_n = 0; step(); step();
    check(busy == 0 && tag_we == 0, "R9", "reset mid-fill", {busy, tag_we}, 2'b00);
    rst_n = 1; step();
    beat_valid = 1; beat_data = 64'h77; step(); beat_valid = 0; step();   // R7 after abort
    fill(32'h4444_4418, 2'd1, 2, 0, 0, 0, 4);   // R10 complete refill after abort
    repeat (3) step();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule